// File: doc/BRIEF.md
# Multi-bus result broadcast arbiter

This block sits between six classes of functional unit and a set of common data buses. Each cycle, any unit that has a finished result raises its request line. It presents its reorder-buffer tag and its 32-bit result with the request. The arbiter picks winners from a single fixed ranking of unit classes and hands out as many buses as it has. The highest-ranked requester takes bus 0, the next takes bus 1, and so on. Each winner's tag and value are then driven onto its bus for one cycle.

Grants are combinational, so a unit learns in the same cycle whether it won. A unit that loses sees its stall line high. It must keep its request, tag and value unchanged into the next cycle, and it keeps competing until it wins. Branch results travel over the same buses, which is how branch outcomes reach the reorder buffer.

Each bus has a saturating counter of the broadcasts it has made. Dividing a counter by elapsed cycles gives that bus's utilisation. The design has no state machine: grant selection is a pure priority chain, and the only state is the registered bus stage and the counters.

Top module: `cdb_arbiter`

## Requirements
- R1: Request bit index encodes the unit class, and a lower index means a higher rank: 0 branch, 1 divide, 2 load/store, 3 multiply, 4 FP add, 5 integer ALU. The granted set is always the min(NUM_CDB, number of requests) lowest-index requesting bits, and no class that is not requesting is granted.
- R2: The k-th granted requester in rank order (k counted from 0) is granted bus k. Bus b's grant field is bits [b*6 +: 6] of `cdb_gnt`, one bit per class, and holds at most one set bit.
- R3: Grants are combinational in the cycle of the request. `req_stall[i]` is high exactly when class i requests and is granted no bus, and any stall implies that every bus is granted.
- R4: In the clock cycle after bus b is granted to class i, `cdb_valid[b]` is 1. In that cycle `cdb_tag[b]` equals class i's tag (TAG_W = log2(ROB_SIZE) bits, field [i*TAG_W +: TAG_W] of `req_tag`), and `cdb_data[b]` equals class i's value (field [i*DATA_W +: DATA_W] of `req_data`).
- R5: A bus that was not granted drives valid low in the following cycle, with its tag and data at zero.
- R6: Each bus's broadcast counter (`bcast_cnt[b*CNT_W +: CNT_W]`) rises by one in the cycle its valid goes out, and holds at all ones once it gets there.
- R7: While reset (`rst_n` low) is asserted, all bus valids, tags, data and counters are zero.
- R8: At most NUM_CDB classes are granted in any cycle, and no class is granted more than one bus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req | input | 6 | Broadcast request per unit class, bit 0 highest rank |
| req_tag | input | 6*TAG_W | Reorder-buffer tag per class |
| req_data | input | 6*DATA_W | Result value per class |
| cdb_gnt | output | NUM_CDB*6 | Per-bus one-hot grant field |
| req_stall | output | 6 | Class requested but won no bus this cycle |
| cdb_valid | output | NUM_CDB | Bus carries a result this cycle |
| cdb_tag | output | NUM_CDB*TAG_W | Tag driven on each bus |
| cdb_data | output | NUM_CDB*DATA_W | Value driven on each bus |
| bcast_cnt | output | NUM_CDB*CNT_W | Saturating broadcast count per bus |

## Verification
The assertions assume that reset is held low for at least one clock before any request. They also assume that request lines are clean logic values at every rising edge. The bench meets this by changing inputs only on the falling edge, after a reset phase. It sweeps every one of the 64 request patterns with a small counter width, so bus 0 is driven into counter saturation. Each pattern carries distinct tags and values, so any wrong steering shows up. The hold rule for losing units is not assumed by any property, so the sweep may present arbitrary patterns back to back.

// File: rtl/cdb_pkg.sv
package cdb_pkg;
    localparam int NUM_CLASS = 6;

    typedef enum logic [2:0] {
        CLS_BRANCH = 3'd0,
        CLS_DIVIDE = 3'd1,
        CLS_LDST   = 3'd2,
        CLS_MULT   = 3'd3,
        CLS_FPADD  = 3'd4,
        CLS_INTALU = 3'd5
    } fu_class_e;
endpackage

// File: rtl/cdb_pick.sv
// Priority chain: each stage takes the lowest set bit of what is left.
module cdb_pick #(
    parameter int NUM_CDB = 2,
    parameter int NUM_REQ = 6
) (
    input  logic [NUM_REQ-1:0]         req,
    output logic [NUM_CDB*NUM_REQ-1:0] gnt,
    output logic [NUM_REQ-1:0]         taken
);
    logic [NUM_REQ-1:0] remain [NUM_CDB+1];

    assign remain[0] = req;

    for (genvar b = 0; b < NUM_CDB; b++) begin : g_stage
        logic [NUM_REQ-1:0] lowest;
        assign lowest        = remain[b] & (~remain[b] + NUM_REQ'(1));
        assign gnt[b*NUM_REQ +: NUM_REQ] = lowest;
        assign remain[b+1]   = remain[b] & ~lowest;
    end

    assign taken = req & ~remain[NUM_CDB];
endmodule

// File: rtl/cdb_bus_slot.sv
// One bus: winner select, output register, saturating broadcast counter.
module cdb_bus_slot #(
    parameter int NUM_REQ = 6,
    parameter int TAG_W   = 4,
    parameter int DATA_W  = 32,
    parameter int CNT_W   = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_REQ-1:0]        gnt,
    input  logic [NUM_REQ*TAG_W-1:0]  req_tag,
    input  logic [NUM_REQ*DATA_W-1:0] req_data,
    output logic                      bus_valid,
    output logic [TAG_W-1:0]          bus_tag,
    output logic [DATA_W-1:0]         bus_data,
    output logic [CNT_W-1:0]          bus_cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [TAG_W-1:0]  sel_tag;
    logic [DATA_W-1:0] sel_data;
    logic              any_gnt;

    always_comb begin
        sel_tag  = '0;
        sel_data = '0;
        for (int i = 0; i < NUM_REQ; i++) begin
            if (gnt[i]) begin
                sel_tag  = sel_tag  | req_tag[i*TAG_W +: TAG_W];
                sel_data = sel_data | req_data[i*DATA_W +: DATA_W];
            end
        end
    end

    assign any_gnt = |gnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_valid <= 1'b0;
            bus_tag   <= '0;
            bus_data  <= '0;
            bus_cnt   <= '0;
        end else begin
            bus_valid <= any_gnt;
            bus_tag   <= sel_tag;
            bus_data  <= sel_data;
            if (any_gnt && bus_cnt != CNT_MAX) begin
                bus_cnt <= bus_cnt + CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/cdb_arbiter.sv
module cdb_arbiter #(
    parameter int NUM_CDB  = 2,
    parameter int ROB_SIZE = 16,
    parameter int DATA_W   = 32,
    parameter int CNT_W    = 16,
    localparam int NREQ    = cdb_pkg::NUM_CLASS,
    localparam int TAG_W   = $clog2(ROB_SIZE)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NREQ-1:0]           req,
    input  logic [NREQ*TAG_W-1:0]     req_tag,
    input  logic [NREQ*DATA_W-1:0]    req_data,
    output logic [NUM_CDB*NREQ-1:0]   cdb_gnt,
    output logic [NREQ-1:0]           req_stall,
    output logic [NUM_CDB-1:0]        cdb_valid,
    output logic [NUM_CDB*TAG_W-1:0]  cdb_tag,
    output logic [NUM_CDB*DATA_W-1:0] cdb_data,
    output logic [NUM_CDB*CNT_W-1:0]  bcast_cnt
);
    logic [NREQ-1:0] taken;

    cdb_pick #(.NUM_CDB(NUM_CDB), .NUM_REQ(NREQ)) u_pick (
        .req   (req),
        .gnt   (cdb_gnt),
        .taken (taken)
    );

    assign req_stall = req & ~taken;

    for (genvar b = 0; b < NUM_CDB; b++) begin : g_bus
        cdb_bus_slot #(
            .NUM_REQ (NREQ),
            .TAG_W   (TAG_W),
            .DATA_W  (DATA_W),
            .CNT_W   (CNT_W)
        ) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .gnt       (cdb_gnt[b*NREQ +: NREQ]),
            .req_tag   (req_tag),
            .req_data  (req_data),
            .bus_valid (cdb_valid[b]),
            .bus_tag   (cdb_tag[b*TAG_W +: TAG_W]),
            .bus_data  (cdb_data[b*DATA_W +: DATA_W]),
            .bus_cnt   (bcast_cnt[b*CNT_W +: CNT_W])
        );
    end
endmodule

// File: rtl/cdb_arbiter_chk.sv
module cdb_arbiter_chk #(
    parameter int NUM_CDB = 2,
    parameter int CNT_W   = 16,
    localparam int NREQ   = cdb_pkg::NUM_CLASS
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [NREQ-1:0]         req,
    input logic [NUM_CDB*NREQ-1:0] cdb_gnt,
    input logic [NREQ-1:0]         req_stall,
    input logic [NUM_CDB-1:0]      cdb_valid,
    input logic [NUM_CDB*CNT_W-1:0] bcast_cnt
);
    logic [NREQ-1:0] gnt_any;
    logic [NREQ:0]   gnt_total;

    always_comb begin
        gnt_any   = '0;
        gnt_total = '0;
        for (int b = 0; b < NUM_CDB; b++) begin
            gnt_any   = gnt_any | cdb_gnt[b*NREQ +: NREQ];
            gnt_total = gnt_total + ($bits(gnt_total))'($countones(cdb_gnt[b*NREQ +: NREQ]));
        end
    end

    AST_GNT_ONLY_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_any & ~req) == '0); // R1

    AST_GNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_total <= ($bits(gnt_total))'(NUM_CDB)); // R8

    AST_GNT_DISTINCT: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_total == ($bits(gnt_total))'($countones(gnt_any))); // R8

    for (genvar b = 0; b < NUM_CDB; b++) begin : g_chk
        AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(cdb_gnt[b*NREQ +: NREQ])); // R2

        AST_STALL_FULL: assert property (@(posedge clk) disable iff (!rst_n)
            (|req_stall) |-> (|cdb_gnt[b*NREQ +: NREQ])); // R3

        AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
            (|cdb_gnt[b*NREQ +: NREQ]) |=> cdb_valid[b]); // R4

        AST_IDLE_BUS: assert property (@(posedge clk) disable iff (!rst_n)
            !(|cdb_gnt[b*NREQ +: NREQ]) |=> !cdb_valid[b]); // R5

        AST_CNT_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
            bcast_cnt[b*CNT_W +: CNT_W] >= $past(bcast_cnt[b*CNT_W +: CNT_W])); // R6
    end
endmodule

bind cdb_arbiter cdb_arbiter_chk #(.NUM_CDB(NUM_CDB), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req),
    .cdb_gnt   (cdb_gnt),
    .req_stall (req_stall),
    .cdb_valid (cdb_valid),
    .bcast_cnt (bcast_cnt)
);

// File: tb/cdb_arbiter_bench.sv
`timescale 1ns/1ps
module cdb_arbiter_bench;
    localparam int NB    = 2;
    localparam int ROBS  = 16;
    localparam int DW    = 32;
    localparam int CW    = 5;
    localparam int NR    = 6;
    localparam int TW    = 4;
    localparam logic [CW-1:0] CMAX = '1;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [NR-1:0]        req = '0;
    logic [NR*TW-1:0]     req_tag = '0;
    logic [NR*DW-1:0]     req_data = '0;
    logic [NB*NR-1:0]     cdb_gnt;
    logic [NR-1:0]        req_stall;
    logic [NB-1:0]        cdb_valid;
    logic [NB*TW-1:0]     cdb_tag;
    logic [NB*DW-1:0]     cdb_data;
    logic [NB*CW-1:0]     bcast_cnt;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    cdb_arbiter #(.NUM_CDB(NB), .ROB_SIZE(ROBS), .DATA_W(DW), .CNT_W(CW)) u_cdb_arbiter (
        .clk(clk), .rst_n(rst_n), .req(req), .req_tag(req_tag), .req_data(req_data),
        .cdb_gnt(cdb_gnt), .req_stall(req_stall), .cdb_valid(cdb_valid),
        .cdb_tag(cdb_tag), .cdb_data(cdb_data), .bcast_cnt(bcast_cnt)
    );

    task automatic check(input string what, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    function automatic logic [TW-1:0] tag_of(input int p, input int c);
        return TW'((c * 3 + p) % ROBS);
    endfunction

    function automatic logic [DW-1:0] data_of(input int p, input int c);
        return 32'hA000_0000 | DW'(p << 8) | DW'(c);
    endfunction

    logic [NR-1:0]  exp_gnt [NB];
    logic           exp_v   [NB];
    logic [TW-1:0]  exp_t   [NB];
    logic [DW-1:0]  exp_d   [NB];
    logic [CW-1:0]  exp_cnt [NB];

    task automatic check_bus_out();
        for (int b = 0; b < NB; b++) begin
            check($sformatf("R4/R5 valid bus%0d", b), 64'(cdb_valid[b]), 64'(exp_v[b]));
            check($sformatf("R4/R5 tag bus%0d", b), 64'(cdb_tag[b*TW +: TW]), 64'(exp_t[b]));
            check($sformatf("R4/R5 data bus%0d", b), 64'(cdb_data[b*DW +: DW]), 64'(exp_d[b]));
            check($sformatf("R6 count bus%0d", b), 64'(bcast_cnt[b*CW +: CW]), 64'(exp_cnt[b]));
        end
    endtask

    initial begin : watchdog
        #100000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : stim
        logic [NR-1:0] exp_stall;
        int nxt;
        for (int b = 0; b < NB; b++) begin
            exp_v[b] = 1'b0; exp_t[b] = '0; exp_d[b] = '0; exp_cnt[b] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R7: reset state
        check("R7 valid in reset", 64'(cdb_valid), 64'(0));
        check("R7 count in reset", 64'(bcast_cnt), 64'(0));
        check("R7 data in reset", 64'(cdb_data), 64'(0));
        rst_n = 1'b1;
        for (int p = 0; p < 64; p++) begin
            @(negedge clk);
            if (p > 0) check_bus_out();
            req = NR'(p);
            for (int c = 0; c < NR; c++) begin
                req_tag[c*TW +: TW]  = tag_of(p, c);
                req_data[c*DW +: DW] = data_of(p, c);
            end
            // Expected grants: walk classes in rank order, fill buses in index order.
            nxt = 0;
            exp_stall = '0;
            for (int b = 0; b < NB; b++) exp_gnt[b] = '0;
            for (int c = 0; c < NR; c++) begin
                if (p[c]) begin
                    if (nxt < NB) begin
                        exp_gnt[nxt][c] = 1'b1;
                        exp_t[nxt] = tag_of(p, c);
                        exp_d[nxt] = data_of(p, c);
                        nxt++;
                    end else begin
                        exp_stall[c] = 1'b1;
                    end
                end
            end
            for (int b = nxt; b < NB; b++) begin
                exp_t[b] = '0;
                exp_d[b] = '0;
            end
            #1;
            for (int b = 0; b < NB; b++) begin
                check($sformatf("R1/R2/R8 grant bus%0d pat%0d", b, p),
                      64'(cdb_gnt[b*NR +: NR]), 64'(exp_gnt[b]));
                exp_v[b] = (b < nxt);
                if (b < nxt && exp_cnt[b] != CMAX) exp_cnt[b] = exp_cnt[b] + 1'b1;
            end
            check($sformatf("R3 stall pat%0d", p), 64'(req_stall), 64'(exp_stall));
        end
        @(negedge clk);
        check_bus_out();
        req = '0;
        for (int b = 0; b < NB; b++) begin
            exp_v[b] = 1'b0; exp_t[b] = '0; exp_d[b] = '0;
        end
        @(negedge clk);
        check_bus_out();
        // R6: bus 0 granted 63 times, must be held at all ones
        check("R6 saturation bus0", 64'(bcast_cnt[0 +: CW]), 64'(CMAX));
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule